// File: doc/BRIEF.md
# Memory Write Protection Monitor

This block sits beside a memory controller and snoops every write request presented to it. Software programs up to two protection windows. Each window has a 64 KB-granular start block and end block packed into one word, and a control word that holds an enable bit and a mask of ports allowed to write inside the window. A write that lands in an enabled window from a port whose mask bit is clear is a violation.

On a violation the block stores the full write address and a status word in a free capture slot. The status word records which windows were hit and the port and subport of the offender. The block then holds its interrupt line high. Software reads the slots and acknowledges each one by writing a 1 to its bit in the event register, usually by writing back the value it read. A slot keeps its first violation until acknowledged. Violations that find both slots taken are dropped.

Top module: `wprot_monitor`

## Requirements
- R1: After reset every register reads as zero and `irq` is low.
- R2: Registers sit at byte offset = word index × 4: window c at 8c, control c at 8c+4 (c = 0,1), event register at 0x10, slot s address at 0x14+8s, slot s status at 0x18+8s. A read returns data on `reg_rdata` one cycle after `reg_rd`. A write whose `reg_addr[1:0]` is nonzero is ignored. Control registers keep bits 24:0 and read zero above.
- R3: A window word holds the start block (address bits 31:16) in bits 15:0 and the end block in bits 31:16. A write hits the window when start ≤ address[31:16] ≤ end, both ends inclusive. A write outside the window is not captured.
- R4: Control bits 23:0 are a permit mask indexed by port ID. A port whose mask bit is set raises no violation. Port IDs 24 to 31 are never permitted.
- R5: A window whose control bit 24 is clear raises no violation. Writing zero to its window and control words turns it off.
- R6: A capture status word has bit 21 set for a window 0 hit and bit 22 for a window 1 hit (both when windows overlap), the 5-bit port at bits 14:10 and the 4-bit subport at bits 9:6, with all other bits zero. The address word holds the full 32-bit write address.
- R7: A violation fills slot 0 if it is free, else slot 1 if it is free, else it is dropped. An occupied slot keeps its contents.
- R8: Event register bit s reads 1 while slot s holds a violation. Writing 1 to bit s frees slot s and zeroes its contents. Writing 0 leaves it unchanged. `irq` is high while any event bit is set.
- R9: A snoop beat with `snp_valid` low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| snp_valid | input | 1 | Snooped write request valid |
| snp_addr | input | 32 | Snooped write byte address |
| snp_port | input | 5 | Requesting port ID |
| snp_sub | input | 4 | Requesting subport ID |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| irq | output | 1 | Violation interrupt, level |

## Verification
The hardest state to reach is both slots occupied while a further violation arrives, followed by a partial acknowledge. The drop path and the refill of only the freed slot are visible only then. The stimulus fires three distinct violations back to back and confirms the third left no trace. It then acknowledges slot 0 alone and sends a fourth violation, which must land in slot 0 while slot 1 still holds the second. A doubly-hit status word also needs care: it needs two enabled windows that overlap on one 64 KB block.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 32;
  localparam int WIN_LSB  = 16;
  localparam int PORT_W   = 5;
  localparam int SUB_W    = 4;
  localparam int MASK_W   = 24;
  localparam int EN_BIT   = 24;
  localparam int NCHAN    = 2;
  localparam int NSLOT    = 2;
  localparam int FLAG_LSB = 21;
  localparam int PORT_LSB = 10;
  localparam int SUB_LSB  = 6;
  localparam int REG_AW   = 6;
endpackage

// File: rtl/wprot_window.sv
module wprot_window #(
  parameter int BLK_W  = 16,
  parameter int PORT_W = 5,
  parameter int MASK_W = 24
) (
  input  logic [2*BLK_W-1:0] win_word,
  input  logic               en,
  input  logic [MASK_W-1:0]  permit,
  input  logic               req_valid,
  input  logic [BLK_W-1:0]   req_blk,
  input  logic [PORT_W-1:0]  req_port,
  output logic               hit
);
  localparam int PSPAN = 1 << PORT_W;

  logic [BLK_W-1:0] start_blk;
  logic [BLK_W-1:0] end_blk;
  logic [PSPAN-1:0] permit_ext;
  logic             in_win;
  logic             allowed;

  assign start_blk = win_word[BLK_W-1:0];
  assign end_blk   = win_word[2*BLK_W-1:BLK_W];

  generate
    if (PSPAN > MASK_W) begin : g_pad
      assign permit_ext = {{(PSPAN-MASK_W){1'b0}}, permit};
    end else begin : g_trim
      assign permit_ext = permit[PSPAN-1:0];
    end
  endgenerate

  always_comb begin
    in_win  = (req_blk >= start_blk) && (req_blk <= end_blk);
    allowed = permit_ext[req_port];
    hit     = req_valid && en && in_win && !allowed;
  end
endmodule

// File: rtl/wprot_capture.sv
module wprot_capture #(
  parameter int NSLOT    = 2,
  parameter int NCHAN    = 2,
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int PORT_W   = 5,
  parameter int SUB_W    = 4,
  parameter int FLAG_LSB = 21,
  parameter int PORT_LSB = 10,
  parameter int SUB_LSB  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCHAN-1:0]         hits,
  input  logic [AW-1:0]            req_addr,
  input  logic [PORT_W-1:0]        req_port,
  input  logic [SUB_W-1:0]         req_sub,
  input  logic [NSLOT-1:0]         clr,
  output logic [NSLOT-1:0]         occ,
  output logic [NSLOT-1:0][AW-1:0] slot_addr,
  output logic [NSLOT-1:0][DW-1:0] slot_stat
);
  logic [NSLOT-1:0]         occ_q, occ_d;
  logic [NSLOT-1:0][AW-1:0] addr_q, addr_d;
  logic [NSLOT-1:0][DW-1:0] stat_q, stat_d;
  logic                     cap_en;
  logic [DW-1:0]            new_stat;
  logic                     taken;

  always_comb begin
    cap_en   = |hits;
    new_stat = '0;
    new_stat[FLAG_LSB +: NCHAN] = hits;
    new_stat[PORT_LSB +: PORT_W] = req_port;
    new_stat[SUB_LSB  +: SUB_W]  = req_sub;
  end

  always_comb begin
    occ_d  = occ_q;
    addr_d = addr_q;
    stat_d = stat_q;
    taken  = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      if (clr[s]) begin
        occ_d[s]  = 1'b0;
        addr_d[s] = '0;
        stat_d[s] = '0;
      end
      if (cap_en && !taken && !occ_q[s]) begin
        occ_d[s]  = 1'b1;
        addr_d[s] = req_addr;
        stat_d[s] = new_stat;
        taken     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      addr_q <= '0;
      stat_q <= '0;
    end else begin
      occ_q  <= occ_d;
      addr_q <= addr_d;
      stat_q <= stat_d;
    end
  end

  assign occ       = occ_q;
  assign slot_addr = addr_q;
  assign slot_stat = stat_q;

  // R7
  first_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !occ_q[0]) |=> (occ_q[0] && addr_q[0] == $past(req_addr)));

  // R7
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q[0] && !clr[0]) |=> $stable(addr_q[0]) && $stable(stat_q[0]));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&occ_q) && clr == '0) |=> ((&occ_q) && $stable(addr_q) && $stable(stat_q)));
endmodule

// File: rtl/wprot_monitor.sv
module wprot_monitor
  import wprot_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int AW     = ADDR_W,
  parameter int PW     = PORT_W,
  parameter int SW     = SUB_W,
  parameter int RAW    = REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snp_valid,
  input  logic [AW-1:0] snp_addr,
  input  logic [PW-1:0] snp_port,
  input  logic [SW-1:0] snp_sub,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int BLK_W     = AW - WIN_LSB;
  localparam int CTL_W     = EN_BIT + 1;
  localparam int IDX_W     = RAW - 2;
  localparam int STAT_IDX  = 2 * NCHAN;
  localparam int SLOT_BASE = STAT_IDX + 1;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [IDX_W-1:0] idx;
  logic             wr_ok;

  assign idx   = reg_addr[RAW-1:2];
  assign wr_ok = reg_wr && (reg_addr[1:0] == 2'b00);

  logic [NCHAN-1:0][2*BLK_W-1:0] win_q, win_d;
  logic [NCHAN-1:0][CTL_W-1:0]   ctl_q, ctl_d;

  always_comb begin
    win_d = win_q;
    ctl_d = ctl_q;
    for (int c = 0; c < NCHAN; c++) begin
      if (wr_ok && idx == IDX_W'(2*c))   win_d[c] = reg_wdata[2*BLK_W-1:0];
      if (wr_ok && idx == IDX_W'(2*c+1)) ctl_d[c] = reg_wdata[CTL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      win_q <= '0;
      ctl_q <= '0;
    end else begin
      win_q <= win_d;
      ctl_q <= ctl_d;
    end
  end

  logic [NCHAN-1:0] hits;

  generate
    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
      wprot_window #(
        .BLK_W (BLK_W),
        .PORT_W(PW),
        .MASK_W(MASK_W)
      ) u_win (
        .win_word (win_q[c]),
        .en       (ctl_q[c][EN_BIT]),
        .permit   (ctl_q[c][MASK_W-1:0]),
        .req_valid(snp_valid),
        .req_blk  (snp_addr[AW-1:WIN_LSB]),
        .req_port (snp_port),
        .hit      (hits[c])
      );
    end
  endgenerate

  logic [NSLOT-1:0]         clr;
  logic [NSLOT-1:0]         occ;
  logic [NSLOT-1:0][AW-1:0] slot_addr;
  logic [NSLOT-1:0][DW-1:0] slot_stat;

  assign clr = (wr_ok && idx == IDX_W'(STAT_IDX)) ? reg_wdata[NSLOT-1:0] : '0;

  wprot_capture #(
    .NSLOT   (NSLOT),
    .NCHAN   (NCHAN),
    .AW      (AW),
    .DW      (DW),
    .PORT_W  (PW),
    .SUB_W   (SW),
    .FLAG_LSB(FLAG_LSB),
    .PORT_LSB(PORT_LSB),
    .SUB_LSB (SUB_LSB)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .hits     (hits),
    .req_addr (snp_addr),
    .req_port (snp_port),
    .req_sub  (snp_sub),
    .clr      (clr),
    .occ      (occ),
    .slot_addr(slot_addr),
    .slot_stat(slot_stat)
  );

  logic [DW-1:0] rd_d, rd_q;

  always_comb begin
    rd_d = '0;
    for (int c = 0; c < NCHAN; c++) begin
      if (idx == IDX_W'(2*c))   rd_d = DW'(win_q[c]);
      if (idx == IDX_W'(2*c+1)) rd_d = DW'(ctl_q[c]);
    end
    if (idx == IDX_W'(STAT_IDX)) rd_d = DW'(occ);
    for (int s = 0; s < NSLOT; s++) begin
      if (idx == IDX_W'(SLOT_BASE + 2*s))     rd_d = DW'(slot_addr[s]);
      if (idx == IDX_W'(SLOT_BASE + 2*s + 1)) rd_d = slot_stat[s];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rd_q <= '0;
    else if (reg_rd) rd_q <= rd_d;
  end

  assign reg_rdata = rd_q;
  assign irq       = |occ;

  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(irq) |-> $past(wr_ok));
endmodule

// File: tb/wprot_monitor_bench.sv
module wprot_monitor_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        snp_valid;
  logic [31:0] snp_addr;
  logic [4:0]  snp_port;
  logic [3:0]  snp_sub;
  logic        reg_wr;
  logic        reg_rd;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wprot_monitor u_wprot_monitor (
    .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .snp_port(snp_port), .snp_sub(snp_sub), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  localparam logic [5:0] OFF_STAT = 6'h10;

  function automatic logic [5:0] off_win(input int c);  return 6'(8*c);     endfunction
  function automatic logic [5:0] off_ctl(input int c);  return 6'(8*c + 4); endfunction
  function automatic logic [5:0] off_sa(input int s);   return 6'(20 + 8*s); endfunction
  function automatic logic [5:0] off_ss(input int s);   return 6'(24 + 8*s); endfunction

  function automatic logic [31:0] stat_word(input logic [1:0] w, input logic [4:0] p,
                                            input logic [3:0] s);
    return (32'(w) << 21) | (32'(p) << 10) | (32'(s) << 6);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic snoop(input logic v, input logic [31:0] a, input logic [4:0] p,
                       input logic [3:0] s);
    @(negedge clk);
    snp_valid = v; snp_addr = a; snp_port = p; snp_sub = s;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic expect_none(input string req);
    expect_rd(req, OFF_STAT, 32'h0);
    chk(req, 32'(irq), 32'h0);
  endtask

  task automatic t_reset();
    chk("R1 irq in reset", 32'(irq), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 9; i++) expect_rd("R1 reg after reset", 6'(4*i), 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);
  endtask

  task automatic t_regs();
    wr(off_win(0), 32'hABCD_1234);
    wr(off_ctl(1), 32'hFFFF_FFFF);
    expect_rd("R2 window readback", off_win(0), 32'hABCD_1234);
    expect_rd("R2 control upper bits", off_ctl(1), 32'h01FF_FFFF);
    wr(6'h01, 32'h5555_5555);
    expect_rd("R2 misaligned write ignored", off_win(0), 32'hABCD_1234);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = off_win(0);
    @(posedge clk); #1;
    chk("R2 one-cycle read latency", reg_rdata, 32'hABCD_1234);
    @(negedge clk); reg_rd = 1'b0;
    wr(off_ctl(1), 32'h0);
  endtask

  task automatic t_window();
    wr(off_win(0), 32'h0012_0010);
    wr(off_ctl(0), 32'h0100_0008);
    snoop(1'b1, 32'h0010_0000, 5'd1, 4'd2);
    expect_rd("R3 start edge addr", off_sa(0), 32'h0010_0000);
    expect_rd("R6 status word ch0", off_ss(0), stat_word(2'b01, 5'd1, 4'd2));
    chk("R8 irq raised", 32'(irq), 32'h1);
    wr(OFF_STAT, 32'h3);
    snoop(1'b1, 32'h0012_FFFC, 5'd2, 4'd0);
    expect_rd("R3 end block inclusive", off_sa(0), 32'h0012_FFFC);
    wr(OFF_STAT, 32'h3);
    snoop(1'b1, 32'h000F_FFFC, 5'd1, 4'd0);
    expect_none("R3 below window");
    snoop(1'b1, 32'h0013_0000, 5'd1, 4'd0);
    expect_none("R3 above window");
  endtask

  task automatic t_mask();
    snoop(1'b1, 32'h0011_0000, 5'd3, 4'd1);
    expect_none("R4 permitted port");
    snoop(1'b1, 32'h0011_0040, 5'd30, 4'd15);
    expect_rd("R4 high port never permitted", off_ss(0), stat_word(2'b01, 5'd30, 4'd15));
    wr(OFF_STAT, 32'h1);
  endtask

  task automatic t_disable();
    wr(off_ctl(0), 32'h0000_0000);
    snoop(1'b1, 32'h0011_0000, 5'd1, 4'd0);
    expect_none("R5 enable clear");
    wr(off_win(0), 32'h0);
    snoop(1'b1, 32'h0000_1000, 5'd1, 4'd0);
    expect_none("R5 zeroed channel off");
    wr(off_win(0), 32'h0012_0010);
    wr(off_ctl(0), 32'h0100_0008);
  endtask

  task automatic t_overlap();
    wr(off_win(1), 32'h0011_0011);
    wr(off_ctl(1), 32'h0100_0000);
    snoop(1'b1, 32'h0011_2340, 5'd7, 4'd10);
    expect_rd("R6 overlap status", off_ss(0), stat_word(2'b11, 5'd7, 4'd10));
    expect_rd("R6 overlap addr", off_sa(0), 32'h0011_2340);
    wr(OFF_STAT, 32'h1);
    wr(off_ctl(1), 32'h0);
  endtask

  task automatic t_fill();
    snoop(1'b1, 32'h0010_0100, 5'd4, 4'd1);
    snoop(1'b1, 32'h0010_0200, 5'd5, 4'd2);
    snoop(1'b1, 32'h0010_0300, 5'd6, 4'd3);
    expect_rd("R7 slot0 first", off_sa(0), 32'h0010_0100);
    expect_rd("R7 slot1 second", off_sa(1), 32'h0010_0200);
    expect_rd("R7 slot1 status", off_ss(1), stat_word(2'b01, 5'd5, 4'd2));
    expect_rd("R8 both pending", OFF_STAT, 32'h3);
    wr(OFF_STAT, 32'h0);
    expect_rd("R8 zero write no effect", OFF_STAT, 32'h3);
    wr(OFF_STAT, 32'h1);
    expect_rd("R8 partial clear", OFF_STAT, 32'h2);
    expect_rd("R8 cleared slot zeroed", off_sa(0), 32'h0);
    chk("R8 irq still high", 32'(irq), 32'h1);
    snoop(1'b1, 32'h0010_0400, 5'd8, 4'd4);
    expect_rd("R7 refill slot0", off_sa(0), 32'h0010_0400);
    expect_rd("R7 slot1 kept", off_sa(1), 32'h0010_0200);
    wr(OFF_STAT, 32'h3);
    chk("R8 irq cleared", 32'(irq), 32'h0);
  endtask

  task automatic t_valid();
    snoop(1'b0, 32'h0010_0000, 5'd1, 4'd0);
    expect_none("R9 invalid beat ignored");
  endtask

  initial begin
    rst_n = 1'b0; snp_valid = 1'b0; snp_addr = '0; snp_port = '0; snp_sub = '0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_window();
    t_mask();
    t_disable();
    t_overlap();
    t_fill();
    t_valid();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule